// File: doc/BRIEF.md
# Shared Bus Arbiter with Mode-Aware Handover

The arbiter decides which of five masters drives one shared bus. The masters are the processor core, a transfer controller, an internal DMA engine, a DMA engine that serves the external bus, and an external agent that asks for the bus to be released. The core is the default owner and wants the bus at all times. The other four raise a request line. The current owner reports, through shared strobes, when its bus cycle ends and which larger transfer unit ends with that cycle. The owner also reports whether it is inside a locked sequence, such as the two halves of a longword access or a read-modify-write.

The bus changes owner only when the current owner reaches a legal release point. Where that point lies depends on the owner's kind and, for the two DMA engines, on their transfer mode. A handover always drops every grant for one idle clock. In that idle clock the next owner is picked by fixed priority, and its grant appears on the following clock. A higher-ranked DMA engine or the external agent may cut into a block or burst of the internal DMA engine. A sleeping core gives up the bus without waiting for a cycle gap. Every pin is a plain control level sampled on the rising clock edge. Nothing flows through the block, so no pin has a valid/ready handshake.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is asserted and on the first clock after it, `gnt_o` equals 5'b00001. The grant bit positions are: bit0 core, bit1 transfer controller, bit2 internal DMA, bit3 external-bus DMA, bit4 external release agent.
- R2: A handover takes three steps. The owner's release point is sampled at an edge, and `gnt_o` becomes 0 after that edge. After the next edge `gnt_o` holds the new owner. Exactly one idle clock separates the two owners.
- R3: `gnt_o` is always one-hot or zero. In the idle clock, the requester picked is the first present in this order: external agent (`req_i[3]`), external-bus DMA (`req_i[2]`), internal DMA (`req_i[1]`), transfer controller (`req_i[0]`). When none of them requests, the core is picked.
- R4: While `lock_i` is high, the owner keeps the bus, even at a cycle gap.
- R5: When the core owns the bus, `cpu_sleep_i` is high and any request is pending, the core releases at once, without waiting for `cyc_end_i`. With no request pending, a sleeping core keeps the grant.
- R6: The transfer controller releases only when `cyc_end_i` and `unit_end_i` are both high. Higher-ranked requests do not preempt it earlier.
- R7: The internal DMA mode is set by `dma_mode_i`. With 2'b00 (single/cycle-steal) it releases at `unit_end_i`. With 2'b01 (block) it releases at `block_end_i`. With 2'b10 or 2'b11 (burst) it releases only at `burst_end_i`. In every mode the strobe counts only together with `cyc_end_i`. At each such point the engine gives the bus back even if it still requests, and the idle-clock pick then decides again.
- R8: The internal DMA engine loses the bus at any cycle gap that is not locked while the external-bus DMA or the external agent requests. This holds in every mode, including the middle of a block or burst.
- R9: The external-bus DMA engine follows the same mode rules, set by `xdm_mode_i`. A request from the external agent does not cut into its transfer.
- R10: While `xdm_yield_en_i` and `int_ext_req_i` are both high, the external-bus DMA engine releases at the next cycle gap that is not locked. It is then passed over in the idle-clock pick for as long as both remain high.
- R11: A non-core owner that drops its request releases at the next cycle gap that is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Requests: bit0 transfer ctrl, bit1 internal DMA, bit2 external-bus DMA, bit3 external agent |
| dma_mode_i | input | 2 | Internal DMA mode: 00 single, 01 block, 1x burst |
| xdm_mode_i | input | 2 | External-bus DMA mode, same encoding |
| cyc_end_i | input | 1 | Owner's current bus cycle ends this clock |
| unit_end_i | input | 1 | Owner finishes a single transfer or unit with this cycle |
| block_end_i | input | 1 | Owner finishes a block with this cycle |
| burst_end_i | input | 1 | Owner finishes its whole transfer with this cycle |
| lock_i | input | 1 | Owner is inside a locked multi-cycle sequence |
| cpu_sleep_i | input | 1 | Core is in sleep |
| xdm_yield_en_i | input | 1 | Lets the external-bus DMA engine yield to internal external-access requests |
| int_ext_req_i | input | 1 | An internal master wants an external access |
| gnt_o | output | 5 | Registered one-hot grant, zero in the idle clock |

## Verification
A corrupted grant register shows at the ports within one clock. The output then carries two bits, or a wrong owner, or an idle clock that lasts longer than one cycle. A release decision taken from the wrong mode strobe shows as a grant that drops one clock after the wrong strobe, or as a grant that stays past the right one. A wrong priority pick shows on the clock after the idle clock. Each scenario therefore fixes the exact clock at which `gnt_o` must change, and the value it must hold just before and just after that clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NM     = 5;
  localparam int NREQ   = NM - 1;
  localparam int MODE_W = 2;

  localparam int M_CPU = 0;
  localparam int M_XFR = 1;
  localparam int M_DMA = 2;
  localparam int M_XDM = 3;
  localparam int M_EXT = 4;

  localparam logic [MODE_W-1:0] XM_SINGLE = 2'd0;
  localparam logic [MODE_W-1:0] XM_BLOCK  = 2'd1;

  // release strobe that matches a DMA engine's transfer mode
  function automatic logic mode_point(input logic [MODE_W-1:0] m,
                                      input logic u, input logic b, input logic s);
    logic r;
    if (m == XM_SINGLE)     r = u;
    else if (m == XM_BLOCK) r = b;
    else                    r = s;
    return r;
  endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic [NM-1:0] cand,
  output logic [NM-1:0] win
);
  // fixed priority: highest index wins, bit0 (core) is always a candidate
  for (genvar i = 0; i < NM; i++) begin : g_win
    if (i == NM - 1) begin : g_top
      assign win[i] = cand[i];
    end else begin : g_low
      assign win[i] = cand[i] & ~(|cand[NM-1:i+1]);
    end
  end
endmodule

// File: rtl/arb_release.sv
module arb_release
  import arb_pkg::*;
(
  input  logic [NM-1:0]     owner,
  input  logic [NM-1:0]     req_all,
  input  logic [MODE_W-1:0] dma_mode,
  input  logic [MODE_W-1:0] xdm_mode,
  input  logic              cyc_end,
  input  logic              unit_end,
  input  logic              block_end,
  input  logic              burst_end,
  input  logic              lock,
  input  logic              sleep,
  input  logic              yield_en,
  input  logic              ext_access,
  output logic              release_now
);
  logic [NM-1:0] rel_v;
  logic others;
  logic slot;

  assign others = |req_all[NM-1:1];
  assign slot   = cyc_end & ~lock;

  for (genvar i = 0; i < NM; i++) begin : g_rel
    if (i == M_CPU) begin : g_cpu
      assign rel_v[i] = ~lock & others & (cyc_end | sleep);
    end else if (i == M_XFR) begin : g_xfr
      assign rel_v[i] = slot & (unit_end | ~req_all[i]);
    end else if (i == M_DMA) begin : g_dma
      assign rel_v[i] = slot & (mode_point(dma_mode, unit_end, block_end, burst_end)
                                | ~req_all[i] | req_all[M_XDM] | req_all[M_EXT]);
    end else if (i == M_XDM) begin : g_xdm
      assign rel_v[i] = slot & (mode_point(xdm_mode, unit_end, block_end, burst_end)
                                | ~req_all[i] | (yield_en & ext_access));
    end else begin : g_ext
      assign rel_v[i] = slot & ~req_all[i];
    end
  end

  assign release_now = |(rel_v & owner);

  // R4: a locked owner never gets a release decision
  always_comb begin
    if (lock) assert_no_release_locked_R4: assert (!release_now);
  end
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_i,
  input  logic [MODE_W-1:0] dma_mode_i,
  input  logic [MODE_W-1:0] xdm_mode_i,
  input  logic              cyc_end_i,
  input  logic              unit_end_i,
  input  logic              block_end_i,
  input  logic              burst_end_i,
  input  logic              lock_i,
  input  logic              cpu_sleep_i,
  input  logic              xdm_yield_en_i,
  input  logic              int_ext_req_i,
  output logic [NM-1:0]     gnt_o
);
  localparam logic [NM-1:0] CPU_ONLY = NM'(1) << M_CPU;

  logic [NM-1:0] gnt_q;
  logic [NM-1:0] req_all;
  logic [NM-1:0] cand;
  logic [NM-1:0] win;
  logic          rel;

  assign req_all = {req_i, 1'b1};

  always_comb begin
    cand        = req_all;
    cand[M_XDM] = req_all[M_XDM] & ~(xdm_yield_en_i & int_ext_req_i);
  end

  arb_pick u_pick (
    .cand (cand),
    .win  (win)
  );

  arb_release u_rel (
    .owner       (gnt_q),
    .req_all     (req_all),
    .dma_mode    (dma_mode_i),
    .xdm_mode    (xdm_mode_i),
    .cyc_end     (cyc_end_i),
    .unit_end    (unit_end_i),
    .block_end   (block_end_i),
    .burst_end   (burst_end_i),
    .lock        (lock_i),
    .sleep       (cpu_sleep_i),
    .yield_en    (xdm_yield_en_i),
    .ext_access  (int_ext_req_i),
    .release_now (rel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gnt_q <= CPU_ONLY;
    else if (gnt_q == '0)   gnt_q <= win;
    else if (rel)           gnt_q <= '0;
  end

  assign gnt_o = gnt_q;

  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && gnt_q != '0) |=> $stable(gnt_q));

  assert_single_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0) |=> (gnt_q != '0));

  assert_xfr_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q[M_XFR] && !unit_end_i && req_i[M_XFR-1]) |=> $stable(gnt_q));

  assert_dma_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q[M_DMA] && cyc_end_i && !lock_i && (req_i[M_XDM-1] || req_i[M_EXT-1]))
      |=> (gnt_q == '0));

  assert_yield_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0 && xdm_yield_en_i && int_ext_req_i) |=> !gnt_q[M_XDM]);
endmodule

// File: tb/shared_bus_arbiter_test.sv
`timescale 1ns/1ps
module shared_bus_arbiter_test;
  localparam logic [4:0] G_IDLE = 5'b00000;
  localparam logic [4:0] G_CPU  = 5'b00001;
  localparam logic [4:0] G_XFR  = 5'b00010;
  localparam logic [4:0] G_DMA  = 5'b00100;
  localparam logic [4:0] G_XDM  = 5'b01000;
  localparam logic [4:0] G_EXT  = 5'b10000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_i = '0;
  logic [1:0] dma_mode_i = '0, xdm_mode_i = '0;
  logic       cyc_end_i = 0, unit_end_i = 0, block_end_i = 0, burst_end_i = 0;
  logic       lock_i = 0, cpu_sleep_i = 0, xdm_yield_en_i = 0, int_ext_req_i = 0;
  logic [4:0] gnt_o;

  int tests = 0, failed = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] e_now;
  string      t_now;

  always #2 clk = ~clk;

  shared_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .dma_mode_i(dma_mode_i), .xdm_mode_i(xdm_mode_i),
    .cyc_end_i(cyc_end_i), .unit_end_i(unit_end_i),
    .block_end_i(block_end_i), .burst_end_i(burst_end_i),
    .lock_i(lock_i), .cpu_sleep_i(cpu_sleep_i),
    .xdm_yield_en_i(xdm_yield_en_i), .int_ext_req_i(int_ext_req_i),
    .gnt_o(gnt_o)
  );

  // monitor: compare the grant after each edge with the scoreboard head
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      e_now = exp_q.pop_front();
      t_now = tag_q.pop_front();
      tests++;
      if (gnt_o !== e_now) begin
        failed++;
        $display("FAIL %s: gnt_o=%b expected=%b", t_now, gnt_o, e_now);
      end
    end
  end

  // driver: current inputs meet the next edge, grant after it must be e
  task automatic cyc(input logic [4:0] e, input string t);
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic strobes(input logic c, input logic u, input logic b, input logic s);
    cyc_end_i = c; unit_end_i = u; block_end_i = b; burst_end_i = s;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    cyc(G_CPU, "R1 in reset");
    cyc(G_CPU, "R1 in reset");
    rst_n = 1;
    cyc(G_CPU, "R1 after reset");
    cyc(G_CPU, "R2 no request keeps core");
    // transfer controller asks
    req_i = 4'b0001;
    cyc(G_CPU, "R2 waits for cycle gap");
    cyc_end_i = 1; lock_i = 1;
    cyc(G_CPU, "R4 locked core keeps bus");
    lock_i = 0;
    cyc(G_IDLE, "R2 idle clock");
    cyc_end_i = 0;
    cyc(G_XFR, "R3 transfer ctrl granted");
    // higher requests do not cut the transfer controller
    req_i = 4'b1011;
    strobes(1, 0, 0, 0);
    cyc(G_XFR, "R6 no unit end keeps bus");
    unit_end_i = 1; lock_i = 1;
    cyc(G_XFR, "R4 locked unit end");
    lock_i = 0;
    cyc(G_IDLE, "R6 release at unit end");
    strobes(0, 0, 0, 0);
    cyc(G_EXT, "R3 external agent first");
    // external agent drops its request
    req_i = 4'b0011;
    cyc(G_EXT, "R11 waits for cycle gap");
    cyc_end_i = 1;
    cyc(G_IDLE, "R11 drop releases");
    cyc_end_i = 0;
    cyc(G_DMA, "R3 dma over transfer ctrl");
    // burst mode
    dma_mode_i = 2'b10;
    strobes(1, 1, 1, 0);
    cyc(G_DMA, "R7 burst ignores unit and block");
    burst_end_i = 1;
    cyc(G_IDLE, "R7 burst end releases");
    strobes(0, 0, 0, 0);
    cyc(G_DMA, "R7 dma picked again");
    // block mode
    dma_mode_i = 2'b01;
    strobes(1, 1, 0, 0);
    cyc(G_DMA, "R7 block ignores unit end");
    strobes(1, 0, 1, 0);
    cyc(G_IDLE, "R7 block end releases");
    strobes(0, 0, 0, 0);
    cyc(G_DMA, "R7 dma picked again");
    // single mode
    dma_mode_i = 2'b00;
    strobes(1, 0, 0, 0);
    cyc(G_DMA, "R7 single needs unit end");
    unit_end_i = 1;
    cyc(G_IDLE, "R7 unit end releases");
    strobes(0, 0, 0, 0);
    cyc(G_DMA, "R7 dma picked again");
    // preemption of a burst by the external-bus DMA
    dma_mode_i = 2'b10;
    req_i = 4'b0111;
    cyc(G_DMA, "R8 waits for cycle gap");
    cyc_end_i = 1;
    cyc(G_IDLE, "R8 burst preempted");
    cyc_end_i = 0;
    cyc(G_XDM, "R3 ext-bus dma over dma");
    // external agent does not cut the ext-bus DMA block
    xdm_mode_i = 2'b01;
    req_i = 4'b1111;
    strobes(1, 0, 0, 0);
    cyc(G_XDM, "R9 not preempted by external agent");
    block_end_i = 1;
    cyc(G_IDLE, "R9 block end releases");
    strobes(0, 0, 0, 0);
    cyc(G_EXT, "R3 external agent first");
    req_i = 4'b0111;
    cyc_end_i = 1;
    cyc(G_IDLE, "R11 external agent drops");
    cyc_end_i = 0;
    cyc(G_XDM, "R3 ext-bus dma picked");
    // temporary yield to an internal external access
    xdm_mode_i = 2'b00;
    xdm_yield_en_i = 1; int_ext_req_i = 1;
    cyc(G_XDM, "R10 waits for cycle gap");
    cyc_end_i = 1;
    cyc(G_IDLE, "R10 yields");
    cyc_end_i = 0;
    cyc(G_DMA, "R10 ext-bus dma passed over");
    xdm_yield_en_i = 0; int_ext_req_i = 0;
    req_i = 4'b0101;
    cyc_end_i = 1;
    cyc(G_IDLE, "R11 dma drops");
    cyc_end_i = 0;
    cyc(G_XDM, "R3 ext-bus dma back");
    cyc_end_i = 1;
    cyc(G_XDM, "R9 single needs unit end");
    unit_end_i = 1;
    cyc(G_IDLE, "R9 unit end releases");
    strobes(0, 0, 0, 0);
    req_i = 4'b0000;
    cyc(G_CPU, "R3 core when nobody asks");
    // sleeping core
    req_i = 4'b0001; cpu_sleep_i = 1;
    cyc(G_IDLE, "R5 sleep releases without gap");
    cpu_sleep_i = 0;
    cyc(G_XFR, "R5 transfer ctrl granted");
    req_i = 4'b0000; cyc_end_i = 1;
    cyc(G_IDLE, "R11 transfer ctrl drops");
    cyc_end_i = 0;
    cyc(G_CPU, "R3 core back");
    cpu_sleep_i = 1;
    cyc(G_CPU, "R5 sleep without request holds");
    cyc(G_CPU, "R5 sleep without request holds");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule